// File: doc/BRIEF.md
# Operator Console Keyboard and Printer Controller

This block sits on the processor I/O bus as the device controller for an operator console made of a keyboard and a printer that types one character at a time. Each bus command carries a device address, an operation kind (start, load or sense), a modifier bit, a 3-bit function code, a control byte and a 16-bit operand address. Commands for other devices are ignored. Keyboard start commands drive two indicator lamps, set the two interrupt enables and clear pending keyboard interrupts. Printer start commands begin a print or a carrier return, set the printer interrupt enable and clear its pending flag. A printer load command fetches one byte from memory into the output register.

The keyboard side captures data characters and four special keys: request, return, end and cancel. It keeps per-key pending flags, gated by a request-key enable and an other-key enable. A sense command returns two bytes: the last typed character and a key-status byte. The single interrupt request output is the OR of every pending flag whose enable is set.

The printer is built around a state machine with four states. `P_IDLE` waits for commands. It goes to `P_FETCH` on a load, to `P_PRINT` on a start with the print bit, and to `P_CRET` on a start with only the carrier-return bit. `P_FETCH` captures the memory byte and returns to `P_IDLE` after one cycle. `P_PRINT` and `P_CRET` count down the busy time and return to `P_IDLE` when the count reaches zero, raising the printer pending flag if the printer interrupt is enabled.

Top module: `con_kp_ctrl`

## Requirements
- R1: A command is acted on only when `io_valid` is high and `io_dev` equals parameter `DEV_ADDR` (default 1). `io_op` encodes 0 = start, 1 = load, 2 = sense and 3 = no operation. A command for another device changes nothing and produces no sense response.
- R2: A keyboard start (op 0, modifier 0, function 0) loads the control byte as follows. Bit 5 goes to `lamp_req`, bit 4 to `lamp_proceed`, bit 2 to the request-key interrupt enable and bit 1 to the other-key interrupt enable.
- R3: A keyboard start with control bit 0 set clears all three keyboard pending flags and the return, end and cancel pressed flags.
- R4: A request key (`key_type` 1) sets the request-pending flag only while the request-key enable is set.
- R5: A data key (`key_type` 0) latches `key_char` as the typed character and clears the return, end and cancel pressed flags. A return key (`key_type` 2) sets the return-pressed flag. Either key sets the data/return pending flag only while the other-key enable is set. `key_type` values 5 to 7 are ignored.
- R6: An end key (`key_type` 3) or a cancel key (`key_type` 4) sets its own pressed flag and clears the other. It sets the end/cancel pending flag only while the other-key enable is set.
- R7: A sense with modifier 0 and function 1 raises `sns_valid` for one cycle, the cycle after the command. `sns_data[15:8]` holds the typed character. `sns_data[7:0]` is the status byte: bit 7 request pending, bit 6 end/cancel pending, bit 5 cancel pressed, bit 4 end pressed, bit 3 data/return pending, bit 2 return pressed, bits 1:0 zero.
- R8: A sense with any other modifier or function, function 3 included, returns `sns_data` = 0 with `sns_valid` high.
- R9: A printer load (op 1, modifier 1, function 0) accepted in `P_IDLE` raises `mem_rd_en` for one cycle, with `mem_rd_addr` equal to `io_addr` minus 1. The byte on `mem_rd_data` in that cycle appears on `prt_data` from the next cycle on.
- R10: A printer start (op 0, modifier 1, function 0) in `P_IDLE` behaves as follows. With bit 7 set it pulses `prt_strobe` for one cycle. With only bit 6 set it pulses `prt_cr_strobe` for one cycle. In both cases `prt_busy` is then high for exactly `PRT_BUSY_CYC` cycles. Bits 7 and 6 are ignored outside `P_IDLE`.
- R11: Every printer start loads control bit 2 into the printer interrupt enable. Bit 0 clears the printer pending flag. The end of a print or carrier return sets the pending flag if the enable is set at that moment.
- R12: `irq` is high exactly when some pending flag is set together with its enable. After reset all lamps, enables, flags, strobes, `prt_data`, `irq` and `sns_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | Bus command valid |
| io_op | input | 2 | Operation kind: 0 start, 1 load, 2 sense, 3 none |
| io_dev | input | 4 | Target device address |
| io_mod | input | 1 | Modifier bit |
| io_func | input | 3 | Function code |
| io_ctrl | input | 8 | Control byte of a start command |
| io_addr | input | 16 | Operand address of a load command |
| sns_valid | output | 1 | Sense response valid |
| sns_data | output | 16 | Sense response bytes |
| mem_rd_en | output | 1 | Memory read request for the print byte |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Memory read data, valid while mem_rd_en is high |
| key_valid | input | 1 | Key event strobe |
| key_type | input | 3 | Key kind: 0 data, 1 request, 2 return, 3 end, 4 cancel |
| key_char | input | 8 | Character code of a data key |
| lamp_req | output | 1 | Request-pending lamp |
| lamp_proceed | output | 1 | Proceed lamp |
| prt_data | output | 8 | Printer output character |
| prt_strobe | output | 1 | One-cycle print pulse |
| prt_cr_strobe | output | 1 | One-cycle carrier-return pulse |
| prt_busy | output | 1 | Printer operation in progress |
| irq | output | 1 | Interrupt request |

## Verification
A long random mix of keyboard starts with arbitrary control bytes, every key kind (unused codes included), foreign-device commands and function-3 senses is compared after each step against a bench model of the status byte, lamps and interrupt. This exposes any gating by the wrong enable or any lost clear. Directed printer cases separate print from carrier return, both bits together, a start issued while busy and completion with the enable on and off. Counting busy cycles checks the length of the busy window. The load case checks the minus-one address and the delay before the byte appears on the output.

// File: rtl/con_kp_pkg.sv
package con_kp_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SENSE = 2'd2,
        OP_NONE  = 2'd3
    } io_op_e;

    localparam logic [2:0] KEY_DATA = 3'd0;
    localparam logic [2:0] KEY_REQ  = 3'd1;
    localparam logic [2:0] KEY_RET  = 3'd2;
    localparam logic [2:0] KEY_END  = 3'd3;
    localparam logic [2:0] KEY_CAN  = 3'd4;

    typedef enum logic [1:0] {
        P_IDLE  = 2'd0,
        P_FETCH = 2'd1,
        P_PRINT = 2'd2,
        P_CRET  = 2'd3
    } prt_state_e;

    typedef struct packed {
        logic kbd_start;
        logic prt_start;
        logic prt_load;
        logic sense_any;
        logic sense_stat;
    } cmd_t;

endpackage

// File: rtl/con_io_decode.sv
module con_io_decode
    import con_kp_pkg::*;
#(
    parameter int DEV_W    = 4,
    parameter int DEV_ADDR = 1
) (
    input  logic             io_valid,
    input  logic [1:0]       io_op,
    input  logic [DEV_W-1:0] io_dev,
    input  logic             io_mod,
    input  logic [2:0]       io_func,
    output cmd_t             cmd
);
    logic hit;
    logic f0;

    assign hit = io_valid && (io_dev == DEV_W'(DEV_ADDR));
    assign f0  = (io_func == 3'd0);

    always_comb begin
        cmd            = '0;
        cmd.kbd_start  = hit && (io_op == OP_START) && !io_mod && f0;
        cmd.prt_start  = hit && (io_op == OP_START) &&  io_mod && f0;
        cmd.prt_load   = hit && (io_op == OP_LOAD)  &&  io_mod && f0;
        cmd.sense_any  = hit && (io_op == OP_SENSE);
        cmd.sense_stat = hit && (io_op == OP_SENSE) && !io_mod && (io_func == 3'd1);
    end
endmodule

// File: rtl/con_kbd_unit.sv
module con_kbd_unit
    import con_kp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kbd_start,
    input  logic [7:0] ctrl,
    input  logic       key_valid,
    input  logic [2:0] key_type,
    input  logic [7:0] key_char,
    output logic       lamp_req,
    output logic       lamp_proceed,
    output logic [7:0] typed_char,
    output logic [7:0] status,
    output logic       irq_kbd
);
    logic req_ie, oth_ie;
    logic req_pend, eoc_pend, rd_pend;
    logic can_f, end_f, ret_f;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lamp_req     <= 1'b0;
            lamp_proceed <= 1'b0;
            req_ie       <= 1'b0;
            oth_ie       <= 1'b0;
            req_pend     <= 1'b0;
            eoc_pend     <= 1'b0;
            rd_pend      <= 1'b0;
            can_f        <= 1'b0;
            end_f        <= 1'b0;
            ret_f        <= 1'b0;
            typed_char   <= 8'h00;
        end else begin
            if (kbd_start) begin
                lamp_req     <= ctrl[5];
                lamp_proceed <= ctrl[4];
                req_ie       <= ctrl[2];
                oth_ie       <= ctrl[1];
                if (ctrl[0]) begin
                    req_pend <= 1'b0;
                    eoc_pend <= 1'b0;
                    rd_pend  <= 1'b0;
                    can_f    <= 1'b0;
                    end_f    <= 1'b0;
                    ret_f    <= 1'b0;
                end
            end
            if (key_valid) begin
                unique case (key_type)
                    KEY_DATA: begin
                        typed_char <= key_char;
                        ret_f      <= 1'b0;
                        end_f      <= 1'b0;
                        can_f      <= 1'b0;
                        if (oth_ie) rd_pend <= 1'b1;
                    end
                    KEY_REQ: begin
                        if (req_ie) req_pend <= 1'b1;
                    end
                    KEY_RET: begin
                        ret_f <= 1'b1;
                        if (oth_ie) rd_pend <= 1'b1;
                    end
                    KEY_END: begin
                        end_f <= 1'b1;
                        can_f <= 1'b0;
                        if (oth_ie) eoc_pend <= 1'b1;
                    end
                    KEY_CAN: begin
                        can_f <= 1'b1;
                        end_f <= 1'b0;
                        if (oth_ie) eoc_pend <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign status  = {req_pend, eoc_pend, can_f, end_f, rd_pend, ret_f, 2'b00};
    assign irq_kbd = (req_pend && req_ie) || ((eoc_pend || rd_pend) && oth_ie);

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_pend) |-> $past(req_ie)); // R4
    AST_EOC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_pend) |-> $past(oth_ie)); // R6
    AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_pend) |-> $past(oth_ie)); // R5
    AST_LAMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_start |=> (lamp_req == $past(ctrl[5]) && lamp_proceed == $past(ctrl[4]))); // R2
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_start && ctrl[0] && !key_valid) |=> (!req_pend && !eoc_pend && !rd_pend)); // R3
endmodule

// File: rtl/con_prt_unit.sv
module con_prt_unit
    import con_kp_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int BUSY_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prt_start,
    input  logic              prt_load,
    input  logic [7:0]        ctrl,
    input  logic [ADDR_W-1:0] addr,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic [7:0]        prt_data,
    output logic              prt_strobe,
    output logic              prt_cr_strobe,
    output logic              prt_busy,
    output logic              irq_prt
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC - 1);

    prt_state_e      state, state_nxt;
    logic [CNT_W-1:0] cnt;
    logic            ie, pend;
    logic            go_print, go_cret;

    assign go_print = prt_start && ctrl[7];
    assign go_cret  = prt_start && !ctrl[7] && ctrl[6];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= P_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            P_IDLE: begin
                if (prt_load)      state_nxt = P_FETCH;
                else if (go_print) state_nxt = P_PRINT;
                else if (go_cret)  state_nxt = P_CRET;
            end
            P_FETCH:         state_nxt = P_IDLE;
            P_PRINT, P_CRET: if (cnt == '0) state_nxt = P_IDLE;
            default:         state_nxt = P_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_en     <= 1'b0;
            mem_rd_addr   <= '0;
            prt_data      <= 8'h00;
            prt_strobe    <= 1'b0;
            prt_cr_strobe <= 1'b0;
            cnt           <= '0;
            ie            <= 1'b0;
            pend          <= 1'b0;
        end else begin
            prt_strobe    <= 1'b0;
            prt_cr_strobe <= 1'b0;
            if (prt_start) begin
                ie <= ctrl[2];
                if (ctrl[0]) pend <= 1'b0;
            end
            unique case (state)
                P_IDLE: begin
                    if (prt_load) begin
                        mem_rd_en   <= 1'b1;
                        mem_rd_addr <= addr - 1'b1;
                    end else if (go_print) begin
                        prt_strobe <= 1'b1;
                        cnt        <= CNT_LOAD;
                    end else if (go_cret) begin
                        prt_cr_strobe <= 1'b1;
                        cnt           <= CNT_LOAD;
                    end
                end
                P_FETCH: begin
                    mem_rd_en <= 1'b0;
                    prt_data  <= mem_rd_data;
                end
                P_PRINT, P_CRET: begin
                    if (cnt == '0) begin
                        if (ie) pend <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign prt_busy = (state == P_PRINT) || (state == P_CRET);
    assign irq_prt  = pend && ie;

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        prt_strobe |=> !prt_strobe); // R10
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(prt_strobe && prt_cr_strobe)); // R10
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (prt_strobe || prt_cr_strobe) |-> prt_busy); // R10
    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_en) |-> (mem_rd_addr == ADDR_W'($past(addr) - 1'b1))); // R9
    AST_PEND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(ie)); // R11
endmodule

// File: rtl/con_kp_ctrl.sv
module con_kp_ctrl
    import con_kp_pkg::*;
#(
    parameter int DEV_ADDR     = 1,
    parameter int PRT_BUSY_CYC = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_valid,
    input  logic [1:0]  io_op,
    input  logic [3:0]  io_dev,
    input  logic        io_mod,
    input  logic [2:0]  io_func,
    input  logic [7:0]  io_ctrl,
    input  logic [15:0] io_addr,
    output logic        sns_valid,
    output logic [15:0] sns_data,
    output logic        mem_rd_en,
    output logic [15:0] mem_rd_addr,
    input  logic [7:0]  mem_rd_data,
    input  logic        key_valid,
    input  logic [2:0]  key_type,
    input  logic [7:0]  key_char,
    output logic        lamp_req,
    output logic        lamp_proceed,
    output logic [7:0]  prt_data,
    output logic        prt_strobe,
    output logic        prt_cr_strobe,
    output logic        prt_busy,
    output logic        irq
);
    cmd_t       cmd;
    logic [7:0] typed_char;
    logic [7:0] kstat;
    logic       irq_kbd, irq_prt;

    con_io_decode #(.DEV_W(4), .DEV_ADDR(DEV_ADDR)) u_dec (
        .io_valid (io_valid),
        .io_op    (io_op),
        .io_dev   (io_dev),
        .io_mod   (io_mod),
        .io_func  (io_func),
        .cmd      (cmd)
    );

    con_kbd_unit u_kbd (
        .clk          (clk),
        .rst_n        (rst_n),
        .kbd_start    (cmd.kbd_start),
        .ctrl         (io_ctrl),
        .key_valid    (key_valid),
        .key_type     (key_type),
        .key_char     (key_char),
        .lamp_req     (lamp_req),
        .lamp_proceed (lamp_proceed),
        .typed_char   (typed_char),
        .status       (kstat),
        .irq_kbd      (irq_kbd)
    );

    con_prt_unit #(.ADDR_W(16), .BUSY_CYC(PRT_BUSY_CYC)) u_prt (
        .clk           (clk),
        .rst_n         (rst_n),
        .prt_start     (cmd.prt_start),
        .prt_load      (cmd.prt_load),
        .ctrl          (io_ctrl),
        .addr          (io_addr),
        .mem_rd_en     (mem_rd_en),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rd_data   (mem_rd_data),
        .prt_data      (prt_data),
        .prt_strobe    (prt_strobe),
        .prt_cr_strobe (prt_cr_strobe),
        .prt_busy      (prt_busy),
        .irq_prt       (irq_prt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sns_valid <= 1'b0;
            sns_data  <= 16'h0000;
        end else begin
            sns_valid <= cmd.sense_any;
            sns_data  <= cmd.sense_stat ? {typed_char, kstat} : 16'h0000;
        end
    end

    assign irq = irq_kbd || irq_prt;

    AST_SNS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sns_valid && !$past(cmd.sense_stat)) |-> (sns_data == 16'h0000)); // R8
    AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(io_valid) && $past(io_dev) != 4'(DEV_ADDR)) |-> !sns_valid); // R1
    AST_SNS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sns_valid && !$past(cmd.sense_any)) |-> 1'b0); // R7
endmodule

// File: tb/con_kp_ctrl_tb_top.sv
module con_kp_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PRT_BUSY   = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        io_valid;
    logic [1:0]  io_op;
    logic [3:0]  io_dev;
    logic        io_mod;
    logic [2:0]  io_func;
    logic [7:0]  io_ctrl;
    logic [15:0] io_addr;
    logic        sns_valid;
    logic [15:0] sns_data;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [7:0]  mem_rd_data;
    logic        key_valid;
    logic [2:0]  key_type;
    logic [7:0]  key_char;
    logic        lamp_req, lamp_proceed;
    logic [7:0]  prt_data;
    logic        prt_strobe, prt_cr_strobe, prt_busy, irq;

    int total = 0;
    int bad   = 0;

    // bench model
    logic m_lreq, m_lpro, m_rie, m_oie, m_rp, m_ep, m_dp, m_can, m_end, m_ret;
    logic [7:0] m_char;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rd_data = mem_rd_addr[7:0] ^ 8'h5A;

    con_kp_ctrl #(.DEV_ADDR(1), .PRT_BUSY_CYC(PRT_BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_op(io_op), .io_dev(io_dev),
        .io_mod(io_mod), .io_func(io_func), .io_ctrl(io_ctrl), .io_addr(io_addr),
        .sns_valid(sns_valid), .sns_data(sns_data), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .key_valid(key_valid),
        .key_type(key_type), .key_char(key_char), .lamp_req(lamp_req),
        .lamp_proceed(lamp_proceed), .prt_data(prt_data), .prt_strobe(prt_strobe),
        .prt_cr_strobe(prt_cr_strobe), .prt_busy(prt_busy), .irq(irq)
    );

    function automatic logic [7:0] exp_status();
        return {m_rp, m_ep, m_can, m_end, m_dp, m_ret, 2'b00};
    endfunction

    function automatic logic exp_kirq();
        return (m_rp && m_rie) || ((m_ep || m_dp) && m_oie);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [3:0] dev, input logic [1:0] op, input logic md,
                       input logic [2:0] fn, input logic [7:0] cb, input logic [15:0] ad);
        io_valid = 1'b1; io_dev = dev; io_op = op; io_mod = md;
        io_func = fn; io_ctrl = cb; io_addr = ad;
        @(negedge clk);
        io_valid = 1'b0;
    endtask

    task automatic kbd_start(input logic [7:0] cb);
        cmd(4'd1, 2'd0, 1'b0, 3'd0, cb, 16'h0);
        m_lreq = cb[5]; m_lpro = cb[4]; m_rie = cb[2]; m_oie = cb[1];
        if (cb[0]) begin
            m_rp = 0; m_ep = 0; m_dp = 0; m_can = 0; m_end = 0; m_ret = 0;
        end
    endtask

    task automatic press(input logic [2:0] kt, input logic [7:0] ch);
        key_valid = 1'b1; key_type = kt; key_char = ch;
        @(negedge clk);
        key_valid = 1'b0;
        case (kt)
            3'd0: begin m_char = ch; m_ret = 0; m_end = 0; m_can = 0; if (m_oie) m_dp = 1; end
            3'd1: if (m_rie) m_rp = 1;
            3'd2: begin m_ret = 1; if (m_oie) m_dp = 1; end
            3'd3: begin m_end = 1; m_can = 0; if (m_oie) m_ep = 1; end
            3'd4: begin m_can = 1; m_end = 0; if (m_oie) m_ep = 1; end
            default: ;
        endcase
    endtask

    task automatic sense_check(input string req);
        cmd(4'd1, 2'd2, 1'b0, 3'd1, 8'h00, 16'h0);
        chk(req, {15'd0, sns_valid}, 32'd1);
        chk(req, {16'd0, sns_data}, {16'd0, m_char, exp_status()});
        chk(req, {29'd0, lamp_req, lamp_proceed, irq}, {29'd0, m_lreq, m_lpro, exp_kirq()});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; io_valid = 0; io_op = 0; io_dev = 0; io_mod = 0; io_func = 0;
        io_ctrl = 0; io_addr = 0; key_valid = 0; key_type = 0; key_char = 0;
        m_lreq = 0; m_lpro = 0; m_rie = 0; m_oie = 0; m_rp = 0; m_ep = 0; m_dp = 0;
        m_can = 0; m_end = 0; m_ret = 0; m_char = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R12 reset state
        chk("R12 reset", {24'd0, lamp_req, lamp_proceed, prt_strobe, prt_cr_strobe,
            prt_busy, irq, sns_valid, mem_rd_en}, 32'd0);
        chk("R12 reset data", {24'd0, prt_data}, 32'd0);

        // directed keyboard corners
        press(3'd1, 8'h00);
        sense_check("R4 request ignored while disabled");
        kbd_start(8'h36);
        sense_check("R2 lamps and enables");
        press(3'd1, 8'h00);
        sense_check("R4 request pending when enabled");
        press(3'd0, 8'hC1);
        sense_check("R5 data key");
        press(3'd4, 8'h00);
        sense_check("R6 cancel key");
        press(3'd3, 8'h00);
        sense_check("R6 end key");
        press(3'd6, 8'hFF);
        sense_check("R5 unused key code ignored");
        kbd_start(8'h01);
        sense_check("R3 clear pending");
        cmd(4'd1, 2'd2, 1'b0, 3'd3, 8'h00, 16'h0);
        chk("R8 sense function 3", {15'd0, sns_valid, sns_data}, 32'h0001_0000);

        // random keyboard mix
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 2) kbd_start(8'($urandom));
            else if (r < 7) press(3'($urandom % 6), 8'($urandom));
            else if (r == 7) begin
                cmd(4'(2 + ($urandom % 14)), 2'($urandom), 1'($urandom), 3'($urandom),
                    8'($urandom), 16'($urandom));
                chk("R1 foreign device no sense", {31'd0, sns_valid}, 32'd0);
            end else begin
                cmd(4'd1, 2'd2, 1'($urandom), 3'd3, 8'h00, 16'h0);
                chk("R8 random zero sense", {15'd0, sns_valid, sns_data}, 32'h0001_0000);
            end
            sense_check("R7 random sense status");
        end

        kbd_start(8'h01);

        // R9 load
        cmd(4'd1, 2'd1, 1'b1, 3'd0, 8'h00, 16'h1235);
        chk("R9 read enable", {31'd0, mem_rd_en}, 32'd1);
        chk("R9 read address", {16'd0, mem_rd_addr}, 32'h1234);
        @(negedge clk);
        chk("R9 read done", {31'd0, mem_rd_en}, 32'd0);
        chk("R9 data latched", {24'd0, prt_data}, 32'h6E);

        // R10/R11 print with interrupt enabled
        cmd(4'd1, 2'd0, 1'b1, 3'd0, 8'h84, 16'h0);
        chk("R10 print strobe", {29'd0, prt_strobe, prt_cr_strobe, prt_busy}, 32'b101);
        for (int k = 1; k < PRT_BUSY; k++) begin
            if (k == 2) begin
                cmd(4'd1, 2'd0, 1'b1, 3'd0, 8'h84, 16'h0);
                chk("R10 start ignored while busy", {30'd0, prt_strobe, prt_busy}, 32'b01);
            end else begin
                @(negedge clk);
                chk("R10 busy window", {30'd0, prt_strobe, prt_busy}, 32'b01);
            end
        end
        @(negedge clk);
        chk("R10 busy ends", {31'd0, prt_busy}, 32'd0);
        chk("R11 printer pending irq", {31'd0, irq}, 32'd1);
        cmd(4'd1, 2'd0, 1'b1, 3'd0, 8'h01, 16'h0);
        chk("R11 reset clears irq", {31'd0, irq}, 32'd0);

        // carrier return, interrupt disabled
        cmd(4'd1, 2'd0, 1'b1, 3'd0, 8'h40, 16'h0);
        chk("R10 carrier return strobe", {29'd0, prt_strobe, prt_cr_strobe, prt_busy}, 32'b011);
        repeat (PRT_BUSY) @(negedge clk);
        chk("R11 no irq when disabled", {30'd0, prt_busy, irq}, 32'd0);

        // both bits: print wins
        cmd(4'd1, 2'd0, 1'b1, 3'd0, 8'hC4, 16'h0);
        chk("R10 print over return", {29'd0, prt_strobe, prt_cr_strobe, prt_busy}, 32'b101);
        repeat (PRT_BUSY) @(negedge clk);
        chk("R12 irq from printer only", {30'd0, prt_busy, irq}, 32'b01);
        kbd_start(8'h02);
        press(3'd2, 8'h00);
        cmd(4'd1, 2'd0, 1'b1, 3'd0, 8'h01, 16'h0);
        chk("R12 irq from keyboard only", {31'd0, irq}, 32'd1);
        kbd_start(8'h00);
        chk("R12 enable off masks irq", {31'd0, irq}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule